// File: doc/BRIEF.md
# Framebuffer Copy/Fill Blitter

This block is a write-triggered blit engine for an 8-bit-per-pixel framebuffer. The framebuffer can also carry a parallel 32-bit-per-pixel direct-colour plane and a 32-bit control plane. One 32-bit command write starts a whole operation. The pixel destination is taken from the address of the write. The data word carries the source pixel address and a run length of 1 to 32 pixels.

A source value of all ones turns the copy into a solid fill that uses the fill colour register. The engine then walks the run in ascending pixel order, one pixel per cycle, through simple synchronous memory ports that have one cycle of read latency. While it works it holds off new commands with a ready signal.

A depth input decides whether the direct-colour plane follows the 8-bit plane. A per-command raw flag extends the update to the control plane. Reads of the blit window return zero. Only full 32-bit accesses start anything.

Top module: `pxblit_engine`

## Requirements
- R1: The destination pixel address is cmd_addr bits 22:3, that is (address >> 3) masked to 20 bits. All other address bits have no effect.
- R2: For a copy, the source pixel address is cmd_wdata bits 19:0 and the run length is cmd_wdata bits 28:24 plus one. Pixel i of the run is read from source+i and written to destination+i, in ascending order, one write per cycle. cmd_wdata bits 31:29 are ignored.
- R3: When cmd_wdata bits 23:0 equal 24'hFFFFFF, no pixel is read. Every destination pixel of the 8-bit plane receives bits 7:0 of the fill colour.
- R4: With deep_mode high at command acceptance, a fill also writes {8'h00, fill colour bits 23:0} to the same positions of the direct-colour plane, and a copy also copies the direct-colour words. With deep_mode low, that plane is never written.
- R5: A command with cmd_raw high and deep_mode high also updates the control plane with the same data rule as the direct-colour plane. Without both conditions, the control plane is never written.
- R6: A write whose cmd_size is not 2'b10 (32-bit) is consumed but writes no plane and does not raise busy.
- R7: An accepted read gives rsp_valid high in the next cycle with rsp_rdata zero, and changes nothing else.
- R8: busy is high for run length + 2 cycles after the accepting edge, and cmd_ready is its inverse. A command held while busy is accepted once busy is low. done pulses for exactly the one cycle in which busy has just fallen.
- R9: The fill colour register resets to zero and is loaded through col_we/col_wdata. A command uses the value held before its accepting edge, so a load during a run does not alter that run.
- R10: A source read returns the writes of destination pixels three or more positions earlier in the same run. It does not return the writes of the two immediately preceding pixels.
- R11: After reset, busy and done are low, cmd_ready is high and no plane read or write enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command access request |
| cmd_ready | output | 1 | Engine can accept an access |
| cmd_write | input | 1 | 1 = write (blit command), 0 = read |
| cmd_raw | input | 1 | Access targets the raw window (control plane also updated) |
| cmd_size | input | 2 | Access size: 00 byte, 01 half, 10 word |
| cmd_addr | input | BUS_AW | Byte address within the blit window |
| cmd_wdata | input | DATA_W | Command word: length, source |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | DATA_W | Read response data (zero) |
| col_we | input | 1 | Fill colour load strobe |
| col_wdata | input | DATA_W | Fill colour value |
| deep_mode | input | 1 | 24-bit depth mode |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| p8_re | output | 1 | 8-bit plane read enable |
| p8_raddr | output | PIX_AW | 8-bit plane read address |
| p8_rdata | input | PIX_W | 8-bit plane read data, one cycle after p8_re |
| p8_we | output | 1 | 8-bit plane write enable |
| p8_waddr | output | PIX_AW | 8-bit plane write address |
| p8_wdata | output | PIX_W | 8-bit plane write data |
| p32_re | output | 1 | Direct-colour plane read enable |
| p32_raddr | output | PIX_AW | Direct-colour plane read address |
| p32_rdata | input | WORD_W | Direct-colour plane read data |
| p32_we | output | 1 | Direct-colour plane write enable |
| p32_waddr | output | PIX_AW | Direct-colour plane write address |
| p32_wdata | output | WORD_W | Direct-colour plane write data |
| pc_re | output | 1 | Control plane read enable |
| pc_raddr | output | PIX_AW | Control plane read address |
| pc_rdata | input | WORD_W | Control plane read data |
| pc_we | output | 1 | Control plane write enable |
| pc_waddr | output | PIX_AW | Control plane write address |
| pc_wdata | output | WORD_W | Control plane write data |

## Verification
The assertions assume the memory behind each plane returns read data exactly one cycle after a read enable. They also assume that a write and a read in the same cycle return the old contents, and that nothing else writes the planes during a run. The bench models all three planes as plain arrays with exactly that timing. It changes deep_mode only while the engine is idle, so the per-command latch of depth is never raced. Commands stay within the first 4096 pixels so that the modelled arrays cover every address the engine touches.

// File: rtl/pxblit_pkg.sv
package pxblit_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/pxblit_decode.sv
module pxblit_decode #(
  parameter int unsigned BUS_AW     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PIX_AW     = 20,
  parameter int unsigned SRC_W      = 24,
  parameter int unsigned LEN_W      = 5,
  parameter int unsigned ADDR_SHIFT = 3
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        size,
  output logic [PIX_AW-1:0] dst,
  output logic [PIX_AW-1:0] src,
  output logic [LEN_W:0]    len,
  output logic              fill,
  output logic              word_ok
);
  import pxblit_pkg::*;

  localparam logic [SRC_W-1:0] FILL_MARK = '1;
  localparam int unsigned      TOP_USED  = SRC_W + LEN_W;

  always_comb begin
    dst     = addr[ADDR_SHIFT +: PIX_AW];
    src     = data[PIX_AW-1:0];
    len     = {1'b0, data[SRC_W +: LEN_W]} + (LEN_W+1)'(1);
    fill    = (data[SRC_W-1:0] == FILL_MARK);
    word_ok = (size == ACC_WORD);
  end

  // address and command bits outside the decoded fields carry no meaning
  logic unused_fields;
  assign unused_fields = ^{addr[BUS_AW-1:ADDR_SHIFT+PIX_AW], addr[ADDR_SHIFT-1:0],
                           data[DATA_W-1:TOP_USED]};
endmodule

// File: rtl/pxblit_colreg.sv
module pxblit_colreg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COL_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [COL_W-1:0]  col
);
  always_ff @(posedge clk) begin
    if (rst)     col <= '0;
    else if (we) col <= wdata[COL_W-1:0];
  end

  logic unused_col_hi;
  assign unused_col_hi = ^wdata[DATA_W-1:COL_W];
endmodule

// File: rtl/pxblit_seq.sv
module pxblit_seq #(
  parameter int unsigned PIX_AW = 20,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned COL_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PIX_AW-1:0] st_dst,
  input  logic [PIX_AW-1:0] st_src,
  input  logic [LEN_W:0]    st_len,
  input  logic              st_fill,
  input  logic              st_deep,
  input  logic              st_raw,
  input  logic [COL_W-1:0]  st_col,
  output logic              busy,
  output logic              done,
  output logic              rd_v,
  output logic [PIX_AW-1:0] rd_addr,
  output logic              s1_v,
  output logic [PIX_AW-1:0] s1_dst,
  output logic              job_fill,
  output logic              job_deep,
  output logic              job_raw,
  output logic [COL_W-1:0]  job_col
);
  logic [PIX_AW-1:0] s0_dst;
  logic [LEN_W:0]    left;
  logic              w_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_v     <= 1'b0;
      rd_addr  <= '0;
      s0_dst   <= '0;
      left     <= '0;
      s1_v     <= 1'b0;
      s1_dst   <= '0;
      w_v      <= 1'b0;
      job_fill <= 1'b0;
      job_deep <= 1'b0;
      job_raw  <= 1'b0;
      job_col  <= '0;
    end else begin
      done   <= 1'b0;
      s1_v   <= rd_v;
      s1_dst <= s0_dst;
      w_v    <= s1_v;
      if (start) begin
        busy     <= 1'b1;
        rd_v     <= 1'b1;
        rd_addr  <= st_src;
        s0_dst   <= st_dst;
        left     <= st_len - (LEN_W+1)'(1);
        job_fill <= st_fill;
        job_deep <= st_deep;
        job_raw  <= st_raw;
        job_col  <= st_col;
      end else if (rd_v) begin
        if (left == '0) begin
          rd_v <= 1'b0;
        end else begin
          left    <= left - (LEN_W+1)'(1);
          rd_addr <= rd_addr + PIX_AW'(1);
          s0_dst  <= s0_dst + PIX_AW'(1);
        end
      end
      // last write is on the port and nothing is behind it
      if (busy && !rd_v && !s1_v && w_v) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_read_in_run_R2: assert property (@(posedge clk) disable iff (rst)
    rd_v |-> busy);
endmodule

// File: rtl/pxblit_wstage.sv
module pxblit_wstage #(
  parameter int unsigned W      = 8,
  parameter int unsigned PIX_AW = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_v,
  input  logic              en,
  input  logic [PIX_AW-1:0] in_addr,
  input  logic              use_fill,
  input  logic [W-1:0]      fill_word,
  input  logic [W-1:0]      rdata,
  output logic              we,
  output logic [PIX_AW-1:0] waddr,
  output logic [W-1:0]      wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we    <= 1'b0;
      waddr <= '0;
      wdata <= '0;
    end else begin
      we    <= in_v & en;
      waddr <= in_addr;
      wdata <= use_fill ? fill_word : rdata;
    end
  end

  assert_ascending_R2: assert property (@(posedge clk) disable iff (rst)
    (we && $past(we)) |-> (waddr == $past(waddr) + PIX_AW'(1)));
endmodule

// File: rtl/pxblit_engine.sv
module pxblit_engine #(
  parameter int unsigned BUS_AW     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PIX_AW     = 20,
  parameter int unsigned PIX_W      = 8,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned SRC_W      = 24,
  parameter int unsigned LEN_W      = 5,
  parameter int unsigned ADDR_SHIFT = 3,
  parameter int unsigned COL_W      = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_raw,
  input  logic [1:0]        cmd_size,
  input  logic [BUS_AW-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              col_we,
  input  logic [DATA_W-1:0] col_wdata,
  input  logic              deep_mode,
  output logic              busy,
  output logic              done,
  output logic              p8_re,
  output logic [PIX_AW-1:0] p8_raddr,
  input  logic [PIX_W-1:0]  p8_rdata,
  output logic              p8_we,
  output logic [PIX_AW-1:0] p8_waddr,
  output logic [PIX_W-1:0]  p8_wdata,
  output logic              p32_re,
  output logic [PIX_AW-1:0] p32_raddr,
  input  logic [WORD_W-1:0] p32_rdata,
  output logic              p32_we,
  output logic [PIX_AW-1:0] p32_waddr,
  output logic [WORD_W-1:0] p32_wdata,
  output logic              pc_re,
  output logic [PIX_AW-1:0] pc_raddr,
  input  logic [WORD_W-1:0] pc_rdata,
  output logic              pc_we,
  output logic [PIX_AW-1:0] pc_waddr,
  output logic [WORD_W-1:0] pc_wdata
);
  import pxblit_pkg::*;

  logic [PIX_AW-1:0] d_dst, d_src, rd_addr, s1_dst;
  logic [LEN_W:0]    d_len;
  logic              d_fill, d_word_ok;
  logic [COL_W-1:0]  col_now, job_col;
  logic              acc, start, rd_v, s1_v;
  logic              job_fill, job_deep, job_raw;
  logic              rd_copy;
  logic [WORD_W-1:0] fill_wide;

  pxblit_decode #(
    .BUS_AW(BUS_AW), .DATA_W(DATA_W), .PIX_AW(PIX_AW),
    .SRC_W(SRC_W), .LEN_W(LEN_W), .ADDR_SHIFT(ADDR_SHIFT)
  ) u_decode (
    .addr(cmd_addr), .data(cmd_wdata), .size(cmd_size),
    .dst(d_dst), .src(d_src), .len(d_len), .fill(d_fill), .word_ok(d_word_ok)
  );

  pxblit_colreg #(.DATA_W(DATA_W), .COL_W(COL_W)) u_colreg (
    .clk(clk), .rst(rst), .we(col_we), .wdata(col_wdata), .col(col_now)
  );

  assign cmd_ready = ~busy;
  assign acc       = cmd_valid & cmd_ready;
  assign start     = acc & cmd_write & d_word_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc & ~cmd_write;
      rsp_rdata <= '0;
    end
  end

  pxblit_seq #(.PIX_AW(PIX_AW), .LEN_W(LEN_W), .COL_W(COL_W)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .st_dst(d_dst), .st_src(d_src), .st_len(d_len), .st_fill(d_fill),
    .st_deep(deep_mode), .st_raw(cmd_raw), .st_col(col_now),
    .busy(busy), .done(done), .rd_v(rd_v), .rd_addr(rd_addr),
    .s1_v(s1_v), .s1_dst(s1_dst),
    .job_fill(job_fill), .job_deep(job_deep), .job_raw(job_raw), .job_col(job_col)
  );

  assign rd_copy   = rd_v & ~job_fill;
  assign p8_re     = rd_copy;
  assign p32_re    = rd_copy & job_deep;
  assign pc_re     = rd_copy & job_deep & job_raw;
  assign p8_raddr  = rd_addr;
  assign p32_raddr = rd_addr;
  assign pc_raddr  = rd_addr;
  assign fill_wide = WORD_W'(job_col);

  pxblit_wstage #(.W(PIX_W), .PIX_AW(PIX_AW)) u_w8 (
    .clk(clk), .rst(rst), .in_v(s1_v), .en(1'b1), .in_addr(s1_dst),
    .use_fill(job_fill), .fill_word(job_col[PIX_W-1:0]), .rdata(p8_rdata),
    .we(p8_we), .waddr(p8_waddr), .wdata(p8_wdata)
  );

  pxblit_wstage #(.W(WORD_W), .PIX_AW(PIX_AW)) u_w32 (
    .clk(clk), .rst(rst), .in_v(s1_v), .en(job_deep), .in_addr(s1_dst),
    .use_fill(job_fill), .fill_word(fill_wide), .rdata(p32_rdata),
    .we(p32_we), .waddr(p32_waddr), .wdata(p32_wdata)
  );

  pxblit_wstage #(.W(WORD_W), .PIX_AW(PIX_AW)) u_wc (
    .clk(clk), .rst(rst), .in_v(s1_v), .en(job_deep & job_raw), .in_addr(s1_dst),
    .use_fill(job_fill), .fill_word(fill_wide), .rdata(pc_rdata),
    .we(pc_we), .waddr(pc_waddr), .wdata(pc_wdata)
  );

  assert_direct_follows_pix_R4: assert property (@(posedge clk) disable iff (rst)
    p32_we |-> (p8_we && p32_waddr == p8_waddr));
  assert_ctrl_follows_direct_R5: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> (p32_we && pc_waddr == p32_waddr));
  assert_narrow_no_run_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_size != ACC_WORD) |=> !busy);
  assert_read_resp_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !cmd_write) |=> (rsp_valid && rsp_rdata == '0 && !busy));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!p8_re && !p8_we));
endmodule

// File: tb/pxblit_engine_bench.sv
module pxblit_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_raw = 1'b0;
  logic [1:0]  cmd_size = 2'b10;
  logic [31:0] cmd_addr = '0, cmd_wdata = '0;
  logic        col_we = 1'b0;
  logic [31:0] col_wdata = '0;
  logic        deep_mode = 1'b0;
  logic        cmd_ready, rsp_valid, busy, done;
  logic [31:0] rsp_rdata;
  logic        p8_re, p8_we, p32_re, p32_we, pc_re, pc_we;
  logic [19:0] p8_raddr, p8_waddr, p32_raddr, p32_waddr, pc_raddr, pc_waddr;
  logic [7:0]  p8_rdata, p8_wdata;
  logic [31:0] p32_rdata, p32_wdata, pc_rdata, pc_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxblit_engine u_pxblit_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_raw(cmd_raw), .cmd_size(cmd_size),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .col_we(col_we), .col_wdata(col_wdata),
    .deep_mode(deep_mode), .busy(busy), .done(done),
    .p8_re(p8_re), .p8_raddr(p8_raddr), .p8_rdata(p8_rdata),
    .p8_we(p8_we), .p8_waddr(p8_waddr), .p8_wdata(p8_wdata),
    .p32_re(p32_re), .p32_raddr(p32_raddr), .p32_rdata(p32_rdata),
    .p32_we(p32_we), .p32_waddr(p32_waddr), .p32_wdata(p32_wdata),
    .pc_re(pc_re), .pc_raddr(pc_raddr), .pc_rdata(pc_rdata),
    .pc_we(pc_we), .pc_waddr(pc_waddr), .pc_wdata(pc_wdata)
  );

  // plane memories: one-cycle read latency, read-before-write on a shared edge
  logic [7:0]  m8 [MEM_N];
  logic [31:0] m32[MEM_N];
  logic [31:0] mc [MEM_N];
  logic [7:0]  e8 [MEM_N];
  logic [31:0] e32[MEM_N];
  logic [31:0] ec [MEM_N];

  always @(posedge clk) begin
    if (p8_re)  p8_rdata  <= m8[p8_raddr[11:0]];
    if (p32_re) p32_rdata <= m32[p32_raddr[11:0]];
    if (pc_re)  pc_rdata  <= mc[pc_raddr[11:0]];
    if (p8_we)  m8[p8_waddr[11:0]]   <= p8_wdata;
    if (p32_we) m32[p32_waddr[11:0]] <= p32_wdata;
    if (pc_we)  mc[pc_waddr[11:0]]   <= pc_wdata;
  end

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // cycle model of the handshake
  logic        mb = 0, md = 0, mrv = 0, macc = 0;
  int          mcnt = 0;
  logic [23:0] mcol = '0, mjcol = '0;

  always @(posedge clk) begin
    logic a;
    if (rst) begin
      mb = 0; md = 0; mrv = 0; macc = 0; mcnt = 0; mcol = '0;
    end else begin
      a    = cmd_valid && !mb;
      macc = a;
      md   = mb && (mcnt == 1);
      if (mb) begin
        mcnt = mcnt - 1;
        if (mcnt == 0) mb = 0;
      end
      mrv = a && !cmd_write;
      if (a && cmd_write && cmd_size == 2'b10) begin
        mb    = 1;
        mcnt  = int'(cmd_wdata[28:24]) + 3;
        mjcol = mcol;
      end
      if (col_we) mcol = col_wdata[23:0];
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (busy !== mb || done !== md || cmd_ready !== !mb || rsp_valid !== mrv ||
          (rsp_valid && rsp_rdata !== 32'h0)) begin
        n_bad++;
        $display("FAIL R8/R7 handshake t=%0t got busy=%b done=%b rdy=%b rv=%b rd=%h exp busy=%b done=%b rdy=%b rv=%b rd=0",
                 $time, busy, done, cmd_ready, rsp_valid, rsp_rdata, mb, md, !mb, mrv);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, got cycle %0d expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic send(input logic raw, input logic wr, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_raw = raw; cmd_write = wr; cmd_size = sz;
    cmd_addr = a; cmd_wdata = d;
    do @(negedge clk); while (!macc);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (mb) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // expected plane contents for an accepted word-size write
  task automatic expect_cmd(input logic raw, input logic deep,
                            input logic [31:0] a, input logic [31:0] d);
    int dst, src, len;
    logic [7:0]  v8 [32];
    logic [31:0] v32[32];
    logic [31:0] vc [32];
    dst = int'(a[22:3]);
    src = int'(d[19:0]);
    len = int'(d[28:24]) + 1;
    if (d[23:0] == 24'hFFFFFF) begin
      for (int i = 0; i < len; i++) begin
        e8[dst+i] = mjcol[7:0];
        if (deep) e32[dst+i] = {8'h00, mjcol};
        if (deep && raw) ec[dst+i] = {8'h00, mjcol};
      end
    end else begin
      for (int k = 0; k < len; k++) begin
        if (k >= 3) begin
          e8[dst+k-3] = v8[k-3];
          if (deep) e32[dst+k-3] = v32[k-3];
          if (deep && raw) ec[dst+k-3] = vc[k-3];
        end
        v8[k] = e8[src+k]; v32[k] = e32[src+k]; vc[k] = ec[src+k];
      end
      for (int j = (len > 3 ? len - 3 : 0); j < len; j++) begin
        e8[dst+j] = v8[j];
        if (deep) e32[dst+j] = v32[j];
        if (deep && raw) ec[dst+j] = vc[j];
      end
    end
  endtask

  task automatic check_mem(input string tag);
    int b8, b32, bc, f8, f32, fc;
    b8 = 0; b32 = 0; bc = 0; f8 = -1; f32 = -1; fc = -1;
    for (int i = 0; i < MEM_N; i++) begin
      if (m8[i]  !== e8[i])  begin b8++;  if (f8  < 0) f8  = i; end
      if (m32[i] !== e32[i]) begin b32++; if (f32 < 0) f32 = i; end
      if (mc[i]  !== ec[i])  begin bc++;  if (fc  < 0) fc  = i; end
    end
    n_chk += 3;
    if (b8 != 0) begin
      n_bad++;
      $display("FAIL %s 8-bit plane @%0d got %h expected %h (%0d diffs)", tag, f8, m8[f8], e8[f8], b8);
    end
    if (b32 != 0) begin
      n_bad++;
      $display("FAIL %s direct plane @%0d got %h expected %h (%0d diffs)", tag, f32, m32[f32], e32[f32], b32);
    end
    if (bc != 0) begin
      n_bad++;
      $display("FAIL %s control plane @%0d got %h expected %h (%0d diffs)", tag, fc, mc[fc], ec[fc], bc);
    end
  endtask

  task automatic run_cmd(input string tag, input logic raw, input logic [31:0] a, input logic [31:0] d);
    send(raw, 1'b1, 2'b10, a, d);
    expect_cmd(raw, deep_mode, a, d);
    wait_idle();
    check_mem(tag);
  endtask

  task automatic load_col(input logic [31:0] v);
    @(negedge clk);
    col_we = 1; col_wdata = v;
    @(negedge clk);
    col_we = 0;
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      m8[i]  = 8'(i * 37 + 5);
      m32[i] = 32'(i) * 32'h00010203 ^ 32'hA5000000;
      mc[i]  = ~(32'(i) * 32'h01000107);
      e8[i]  = m8[i];
      e32[i] = m32[i];
      ec[i]  = mc[i];
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state
    n_chk++;
    if (busy !== 0 || done !== 0 || cmd_ready !== 1 || p8_re !== 0 || p8_we !== 0 ||
        p32_we !== 0 || pc_we !== 0) begin
      n_bad++;
      $display("FAIL R11 reset state got busy=%b done=%b rdy=%b re=%b we=%b/%b/%b expected 0 0 1 0 0/0/0",
               busy, done, cmd_ready, p8_re, p8_we, p32_we, pc_we);
    end

    // R9: fill colour resets to zero
    deep_mode = 1;
    run_cmd("R9 reset colour", 1'b1, 32'(100) << 3, 32'h03FFFFFF);

    load_col(32'hAB12C3D4);
    // R3: 8-bit fill, direct plane untouched in shallow mode
    deep_mode = 0;
    run_cmd("R3 fill shallow", 1'b1, 32'(200) << 3, 32'h04FFFFFF);
    // R4: 32-pixel fill in deep mode, bits 31:29 ignored, control plane untouched
    deep_mode = 1;
    run_cmd("R4 fill deep len32", 1'b0, 32'(300) << 3, 32'hFFFFFFFF);
    // R1 R2: shallow copy, low and high address bits ignored
    deep_mode = 0;
    run_cmd("R1 R2 copy shallow", 1'b0, (32'(1500) << 3) | 32'h10000005, 32'h060003E8);
    // R2 R4: single-pixel deep copy
    deep_mode = 1;
    run_cmd("R2 R4 copy len1", 1'b0, 32'(1600) << 3, 32'h0000044C);
    // R5: raw copy and raw fill
    run_cmd("R5 raw copy", 1'b1, 32'(2100) << 3, 32'h130007D0);
    run_cmd("R5 raw fill", 1'b1, 32'(2300) << 3, 32'h02FFFFFF);
    // R10: overlapping runs
    run_cmd("R10 overlap +1", 1'b1, 32'(3001) << 3, 32'h09000BB8);
    run_cmd("R10 overlap +3", 1'b1, 32'(3103) << 3, 32'h0B000C1C);
    run_cmd("R10 overlap -5", 1'b0, 32'(3200) << 3, 32'h0F000C85);

    // R6: narrow write consumed with no effect
    send(1'b1, 1'b1, 2'b01, 32'(3500) << 3, 32'h07FFFFFF);
    wait_idle();
    check_mem("R6 narrow write");
    send(1'b0, 1'b1, 2'b00, 32'(3510) << 3, 32'h07000010);
    wait_idle();
    check_mem("R6 byte write");

    // R7: read returns zero, changes nothing
    send(1'b0, 1'b0, 2'b10, 32'(3600) << 3, 32'h0);
    n_chk++;
    if (rsp_valid !== 1 || rsp_rdata !== 32'h0) begin
      n_bad++;
      $display("FAIL R7 read response got v=%b d=%h expected v=1 d=0", rsp_valid, rsp_rdata);
    end
    wait_idle();
    check_mem("R7 read");

    // R8 R9: command held while busy, colour load during a run
    deep_mode = 1;
    send(1'b1, 1'b1, 2'b10, 32'(3700) << 3, 32'h1FFFFFFF);
    expect_cmd(1'b1, 1'b1, 32'(3700) << 3, 32'h1FFFFFFF);
    @(negedge clk);
    col_we = 1; col_wdata = 32'h00FEDCBA;
    @(negedge clk);
    col_we = 0;
    send(1'b1, 1'b1, 2'b10, 32'(3800) << 3, 32'h05FFFFFF);
    expect_cmd(1'b1, 1'b1, 32'(3800) << 3, 32'h05FFFFFF);
    send(1'b0, 1'b1, 2'b10, 32'(3900) << 3, 32'h08000E74);
    expect_cmd(1'b0, 1'b1, 32'(3900) << 3, 32'h08000E74);
    wait_idle();
    check_mem("R8 R9 back-to-back");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule